// File: doc/BRIEF.md
# Double-SHA-256 Nonce Search Engine

This block looks for a 32-bit nonce that makes the double SHA-256 digest of an 80-byte header fall strictly below a loadable 256-bit target. The header's first 64-byte chunk does not depend on the nonce. The host therefore supplies that chunk already compressed, as a 256-bit chaining state. Along with it the host supplies the twelve header bytes that precede the nonce, a starting nonce and the target. The host then pulses `start`.

For each candidate, the engine compresses the second chunk from the supplied chaining state. The nonce occupies the last four bytes of the header and sits at byte offset 12 of that chunk. The engine then hashes the resulting 32-byte digest once more, starting from the standard SHA-256 initial values. Both passes share one iterative core that computes one round per clock.

The final digest is read as a little-endian 256-bit integer. Its most significant 32-bit word is tested against the target first, and only candidates that survive that cheap test reach the full 256-bit comparison. The search stops at the first hit. If no hit is found, it stops once the whole nonce span has been tried.

Top module: `pow_nonce_search`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `busy_o`, `found_o` and `exhausted_o` are all low.
- R2: The digest of a candidate is computed in two passes. First, SHA-256 compression runs on the second chunk, starting from `midstate_i`. Second, a full SHA-256 runs over the resulting 32-byte value, padded as a 256-bit message, starting from the standard initial values. `digest_o` carries the first digest word in bits [255:224].
- R3: The second chunk is laid out as follows:
  - message bytes 0..11 are `head_i`, with the first byte taken from bits [95:88];
  - bytes 12..15 are the nonce in little-endian order, with byte 12 equal to nonce bits [7:0];
  - then comes a 0x80 byte, zero fill, and a 64-bit big-endian length of 640.
- R4: A candidate is a hit only when its digest, read as a little-endian integer, is strictly less than `target_i`. In that integer, byte k is digest byte k, and digest byte 0 is `digest_o[255:248]`. A digest equal to the target is not a hit.
- R5: Before the full compare, the top 32 bits of that integer are checked against the target. In the default variant the check is "not above the top target word"; with `ZERO_PRECHECK` set the check is "equal to zero". A candidate that fails the check is treated as a miss.
- R6: Candidates are tried in order: `nonce_i`, then `nonce_i`+1, and so on, modulo 2^32. The first hit in that order is the one reported.
- R7: If none of the 2^`SPAN_BITS` candidates hits, `exhausted_o` rises and `nonce_o` shows the last candidate tried. `found_o` stays low. With the default of 32 this is the point where the nonce would wrap back to its starting value.
- R8: On a hit, `found_o` goes high and `busy_o` goes low. `nonce_o` and `digest_o` then stay unchanged until the next `start`.
- R9: A `start` cycle loads all inputs. It discards any search in progress, clears `found_o` and `exhausted_o`, and raises `busy_o` from the next cycle.
- R10: `found_o` and `exhausted_o` are never high together. Neither of them is high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load inputs and begin a new search |
| midstate_i | input | 256 | Chaining state after the first chunk, first word in [255:224] |
| head_i | input | 96 | Header bytes 64..75, first byte in [95:88] |
| nonce_i | input | 32 | First nonce to try |
| target_i | input | 256 | Target as an unsigned 256-bit integer |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | A hit was found; held until next start |
| exhausted_o | output | 1 | All candidates tried without a hit |
| nonce_o | output | 32 | Winning nonce, or last candidate tried |
| digest_o | output | 256 | Final digest of that nonce |

## Verification
The properties assume that `start` is sampled only on rising clock edges and that reset is synchronous. They also assume that the inputs matter only in the cycle in which `start` is high, so changes to them between starts are ignored by design. The stimulus changes all inputs only on falling edges and holds `start` for exactly one cycle. The bench waits for `busy_o` to fall before it starts again, except in the restart case, which deliberately pulses `start` in the middle of a search. Targets are chosen from a software double-hash of the same candidates, so every expected hit or exhaustion is known before the search runs.

// File: rtl/pow_search_pkg.sv
package pow_search_pkg;

   localparam int WORD_W   = 32;
   localparam int DIGEST_W = 256;
   localparam int BLOCK_W  = 512;
   localparam int N_ROUNDS = 64;
   localparam int N_WORDS  = BLOCK_W / WORD_W;
   localparam int N_STATE  = DIGEST_W / WORD_W;

   typedef logic [WORD_W-1:0] word_t;

   localparam logic [DIGEST_W-1:0] SHA_IV = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

   localparam word_t K_TAB [0:N_ROUNDS-1] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
      32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
      32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
      32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
      32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
      32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
      32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
      32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
      32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

   typedef enum logic [2:0] {
      ST_IDLE, ST_P1_GO, ST_P1_RUN, ST_P2_GO, ST_P2_RUN, ST_PRE, ST_FULL
   } phase_t;

   function automatic word_t rotr(input word_t x, input int n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t big_s0(input word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_s1(input word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t sml_s0(input word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t sml_s1(input word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

endpackage

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
   import pow_search_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [DIGEST_W-1:0] init_state,
   input  logic [BLOCK_W-1:0]  block,
   output logic                done,
   output logic [DIGEST_W-1:0] digest
);

   localparam int RND_W = $clog2(N_ROUNDS);

   word_t             st    [0:N_STATE-1];
   word_t             chain [0:N_STATE-1];
   word_t             win   [0:N_WORDS-1];
   logic [RND_W-1:0]  rnd;
   logic              running;
   logic              fin;
   word_t             t1, t2, w_new;

   always_comb begin
      t1 = st[7] + big_s1(st[4]) + ((st[4] & st[5]) ^ (~st[4] & st[6]))
         + K_TAB[rnd] + win[0];
      t2 = big_s0(st[0]) + ((st[0] & st[1]) ^ (st[0] & st[2]) ^ (st[1] & st[2]));
      w_new = sml_s1(win[14]) + win[9] + sml_s0(win[1]) + win[0];
   end

   // control: round counter and phase flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         fin     <= 1'b0;
         done    <= 1'b0;
         rnd     <= '0;
      end else if (load) begin
         running <= 1'b1;
         fin     <= 1'b0;
         done    <= 1'b0;
         rnd     <= '0;
      end else if (running) begin
         done <= 1'b0;
         rnd  <= rnd + 1'b1;
         if (rnd == RND_W'(N_ROUNDS - 1)) begin
            running <= 1'b0;
            fin     <= 1'b1;
         end
      end else if (fin) begin
         fin  <= 1'b0;
         done <= 1'b1;
      end else begin
         done <= 1'b0;
      end
   end

   // datapath: working variables, rolling schedule, final add
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         digest <= '0;
      end else if (load) begin
         for (int j = 0; j < N_STATE; j++) begin
            st[j]    <= init_state[DIGEST_W-1-WORD_W*j -: WORD_W];
            chain[j] <= init_state[DIGEST_W-1-WORD_W*j -: WORD_W];
         end
         for (int j = 0; j < N_WORDS; j++)
            win[j] <= block[BLOCK_W-1-WORD_W*j -: WORD_W];
      end else if (running) begin
         st[0] <= t1 + t2;
         st[1] <= st[0];
         st[2] <= st[1];
         st[3] <= st[2];
         st[4] <= st[3] + t1;
         st[5] <= st[4];
         st[6] <= st[5];
         st[7] <= st[6];
         for (int j = 0; j < N_WORDS-1; j++)
            win[j] <= win[j+1];
         win[N_WORDS-1] <= w_new;
      end else if (fin) begin
         for (int j = 0; j < N_STATE; j++)
            digest[DIGEST_W-1-WORD_W*j -: WORD_W] <= chain[j] + st[j];
      end
   end

endmodule

// File: rtl/pow_block_build.sv
module pow_block_build
   import pow_search_pkg::*;
(
   input  logic                second_pass,
   input  logic [95:0]         head,
   input  word_t               nonce,
   input  logic [DIGEST_W-1:0] first_digest,
   output logic [BLOCK_W-1:0]  block
);

   localparam word_t PAD_ONE   = 32'h8000_0000;
   localparam word_t LEN_CHUNK = 32'd640;
   localparam word_t LEN_DIG   = 32'd256;

   word_t nonce_le;

   // nonce bytes go into the header least significant byte first
   always_comb begin
      nonce_le = {nonce[7:0], nonce[15:8], nonce[23:16], nonce[31:24]};
      if (second_pass)
         block = {first_digest, PAD_ONE, 192'd0, LEN_DIG};
      else
         block = {head, nonce_le, PAD_ONE, 320'd0, LEN_CHUNK};
   end

endmodule

// File: rtl/pow_target_cmp.sv
module pow_target_cmp
   import pow_search_pkg::*;
#(
   parameter bit ZERO_PRECHECK = 1'b0
)(
   input  logic [DIGEST_W-1:0] digest,
   input  logic [DIGEST_W-1:0] target,
   output logic                pre_ok,
   output logic                below
);

   localparam int N_BYTES = DIGEST_W / 8;

   logic [DIGEST_W-1:0] value_le;

   // digest byte k becomes byte k of the little-endian integer
   for (genvar k = 0; k < N_BYTES; k++) begin : g_swap
      assign value_le[8*k +: 8] = digest[DIGEST_W-1-8*k -: 8];
   end

   if (ZERO_PRECHECK) begin : g_pre_zero
      assign pre_ok = (value_le[DIGEST_W-1 -: WORD_W] == '0);
   end else begin : g_pre_top
      assign pre_ok = (value_le[DIGEST_W-1 -: WORD_W] <= target[DIGEST_W-1 -: WORD_W]);
   end

   assign below = (value_le < target);

endmodule

// File: rtl/pow_nonce_search.sv
module pow_nonce_search
   import pow_search_pkg::*;
#(
   parameter int SPAN_BITS     = 32,
   parameter bit ZERO_PRECHECK = 1'b0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [255:0] midstate_i,
   input  logic [95:0]  head_i,
   input  logic [31:0]  nonce_i,
   input  logic [255:0] target_i,
   output logic         busy_o,
   output logic         found_o,
   output logic         exhausted_o,
   output logic [31:0]  nonce_o,
   output logic [255:0] digest_o
);

   if (SPAN_BITS < 1 || SPAN_BITS > WORD_W) begin : g_bad_span
      $error("SPAN_BITS must lie in 1..32");
   end

   phase_t                state_q;
   logic [DIGEST_W-1:0]   mid_q, tgt_q, dig1_q, dig2_q;
   logic [95:0]           head_q;
   word_t                 nonce_q;
   logic [SPAN_BITS-1:0]  cnt_q;

   logic                  core_load, core_done;
   logic [DIGEST_W-1:0]   core_init, core_digest;
   logic [BLOCK_W-1:0]    core_block;
   logic                  pre_ok, below, hit, miss, last_cand;

   assign core_load = (state_q == ST_P1_GO) || (state_q == ST_P2_GO);
   assign core_init = (state_q == ST_P2_GO) ? SHA_IV : mid_q;
   assign hit       = (state_q == ST_FULL) && below;
   assign miss      = ((state_q == ST_PRE) && !pre_ok) || ((state_q == ST_FULL) && !below);
   assign last_cand = &cnt_q;
   assign busy_o    = (state_q != ST_IDLE);

   pow_block_build u_build (
      .second_pass (state_q == ST_P2_GO),
      .head        (head_q),
      .nonce       (nonce_q),
      .first_digest(dig1_q),
      .block       (core_block)
   );

   sha256_iter_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (core_load),
      .init_state(core_init),
      .block     (core_block),
      .done      (core_done),
      .digest    (core_digest)
   );

   pow_target_cmp #(.ZERO_PRECHECK(ZERO_PRECHECK)) u_cmp (
      .digest(dig2_q),
      .target(tgt_q),
      .pre_ok(pre_ok),
      .below (below)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         found_o     <= 1'b0;
         exhausted_o <= 1'b0;
         nonce_o     <= '0;
         digest_o    <= '0;
         cnt_q       <= '0;
      end else if (start) begin
         mid_q       <= midstate_i;
         head_q      <= head_i;
         tgt_q       <= target_i;
         nonce_q     <= nonce_i;
         cnt_q       <= '0;
         found_o     <= 1'b0;
         exhausted_o <= 1'b0;
         state_q     <= ST_P1_GO;
      end else if (hit) begin
         found_o  <= 1'b1;
         nonce_o  <= nonce_q;
         digest_o <= dig2_q;
         state_q  <= ST_IDLE;
      end else if (miss) begin
         if (last_cand) begin
            exhausted_o <= 1'b1;
            nonce_o     <= nonce_q;
            digest_o    <= dig2_q;
            state_q     <= ST_IDLE;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            nonce_q <= nonce_q + 1'b1;
            state_q <= ST_P1_GO;
         end
      end else begin
         unique case (state_q)
            ST_P1_GO:  state_q <= ST_P1_RUN;
            ST_P1_RUN: if (core_done) begin
                          dig1_q  <= core_digest;
                          state_q <= ST_P2_GO;
                       end
            ST_P2_GO:  state_q <= ST_P2_RUN;
            ST_P2_RUN: if (core_done) begin
                          dig2_q  <= core_digest;
                          state_q <= ST_PRE;
                       end
            ST_PRE:    state_q <= ST_FULL;
            default:   state_q <= state_q;
         endcase
      end
   end

endmodule

// File: rtl/pow_nonce_search_chk.sv
module pow_nonce_search_chk (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy_o,
   input logic         found_o,
   input logic         exhausted_o,
   input logic [31:0]  nonce_o,
   input logic [255:0] digest_o
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !busy_o && !found_o && !exhausted_o);

   assert_found_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      found_o && !start |=> found_o && $stable(nonce_o) && $stable(digest_o));

   assert_exhaust_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted_o && !start |=> exhausted_o && !found_o && $stable(nonce_o));

   assert_exhaust_from_search_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exhausted_o) |-> $past(busy_o));

   assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_o && !found_o && !exhausted_o);

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(found_o && exhausted_o));

   assert_idle_when_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (found_o || exhausted_o) |-> !busy_o);

endmodule

bind pow_nonce_search pow_nonce_search_chk u_chk (.*);

// File: tb/pow_nonce_search_test.sv
module pow_nonce_search_test;

   localparam int TB_SPAN = 3;
   localparam int N_CAND  = 1 << TB_SPAN;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] midstate_i = '0;
   logic [95:0]  head_i = '0;
   logic [31:0]  nonce_i = '0;
   logic [255:0] target_i = '0;
   logic         busy_o, found_o, exhausted_o;
   logic [31:0]  nonce_o;
   logic [255:0] digest_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   pow_nonce_search #(.SPAN_BITS(TB_SPAN)) uut (.*);

   localparam logic [31:0] KC [0:63] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

   localparam logic [255:0] IV0 = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [255:0] ref_compress(input logic [255:0] hin, input logic [511:0] blk);
      logic [31:0] w [0:63];
      logic [31:0] v [0:7];
      logic [31:0] t1, t2, s0, s1;
      logic [255:0] res;
      for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
      for (int t = 16; t < 64; t++) begin
         s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
         s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
         w[t] = s1 + w[t-7] + s0 + w[t-16];
      end
      for (int j = 0; j < 8; j++) v[j] = hin[255-32*j -: 32];
      for (int t = 0; t < 64; t++) begin
         t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
            + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KC[t] + w[t];
         t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
            + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
         for (int j = 7; j > 0; j--) v[j] = v[j-1];
         v[4] = v[4] + t1;
         v[0] = t1 + t2;
      end
      for (int j = 0; j < 8; j++) res[255-32*j -: 32] = hin[255-32*j -: 32] + v[j];
      return res;
   endfunction

   // R2 R3: chunk layout and double hash, per the requirement text
   function automatic logic [255:0] ref_double(input logic [255:0] mid, input logic [95:0] head,
                                               input logic [31:0] n);
      logic [511:0] b1, b2;
      logic [255:0] d1;
      b1 = {head, n[7:0], n[15:8], n[23:16], n[31:24], 32'h80000000, 320'd0, 32'd640};
      d1 = ref_compress(mid, b1);
      b2 = {d1, 32'h80000000, 192'd0, 32'd256};
      return ref_compress(IV0, b2);
   endfunction

   function automatic logic [255:0] ref_le(input logic [255:0] d);
      logic [255:0] r;
      for (int k = 0; k < 32; k++) r[8*k +: 8] = d[255-8*k -: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report_and_end();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic pulse_start(input logic [255:0] mid, input logic [95:0] head,
                              input logic [31:0] s, input logic [255:0] tgt);
      @(negedge clk);
      midstate_i = mid; head_i = head; nonce_i = s; target_i = tgt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
   endtask

   // launch a search and compare its outcome with the software model
   task automatic run_case(input string req, input logic [255:0] mid, input logic [95:0] head,
                           input logic [31:0] s, input logic [255:0] tgt);
      bit exp_found = 1'b0;
      logic [31:0]  en = s + 32'(N_CAND - 1);
      logic [255:0] ed, d;
      for (int k = 0; k < N_CAND; k++) begin
         d = ref_double(mid, head, s + 32'(k));
         if (!exp_found && ref_le(d) < tgt) begin
            exp_found = 1'b1; en = s + 32'(k); ed = d;
         end
         if (!exp_found && k == N_CAND - 1) ed = d;
      end
      pulse_start(mid, head, s, tgt);
      check(busy_o == 1'b1, {req, " R9 busy after start"}, 256'(busy_o), 256'd1);
      wait_idle();
      check(found_o == exp_found, {req, " found"}, 256'(found_o), 256'(exp_found));
      check(exhausted_o == !exp_found, {req, " R7 exhausted"}, 256'(exhausted_o), 256'(!exp_found));
      check(nonce_o == en, {req, " R6 nonce"}, 256'(nonce_o), 256'(en));
      check(digest_o == ed, {req, " R2 R3 digest"}, digest_o, ed);
      check(!(found_o && exhausted_o), "R10 flags exclusive", 256'({found_o, exhausted_o}), 256'd0);
   endtask

   logic [255:0] MID_A = 256'h0123456789abcdef_fedcba9876543210_deadbeefcafef00d_0badc0de13579bdf;
   logic [95:0]  HEAD_A = 96'h11223344_55667788_99aabbcc;

   task automatic t_reset();
      check(!busy_o && !found_o && !exhausted_o, "R1 reset state",
            256'({busy_o, found_o, exhausted_o}), 256'd0);
   endtask

   task automatic t_permissive();
      // any digest is below all-ones except all-ones itself: first nonce hits
      run_case("R4 R6 permissive", MID_A, HEAD_A, 32'h12345678, {256{1'b1}});
      check(nonce_o == 32'h12345678, "R6 first candidate", 256'(nonce_o), 256'h12345678);
   endtask

   task automatic t_equal_boundary();
      logic [255:0] mn = {256{1'b1}};
      logic [255:0] v;
      int arg = 0;
      for (int k = 0; k < N_CAND; k++) begin
         v = ref_le(ref_double(MID_A, HEAD_A, 32'h00000100 + 32'(k)));
         if (v < mn) begin mn = v; arg = k; end
      end
      // R4: target equal to the smallest digest -> no hit at all
      run_case("R4 equal target", MID_A, HEAD_A, 32'h00000100, mn);
      check(exhausted_o == 1'b1, "R4 equal is not below", 256'(exhausted_o), 256'd1);
      // R4 R6: one above the smallest -> hit exactly at its nonce
      run_case("R4 R6 min plus one", MID_A, HEAD_A, 32'h00000100, mn + 256'd1);
      check(nonce_o == 32'h00000100 + 32'(arg), "R6 chosen hit nonce", 256'(nonce_o),
            256'(32'h00000100 + 32'(arg)));
   endtask

   task automatic t_zero_target_wrap();
      // R7: zero target never hits; start near the top to cross the 32-bit wrap
      run_case("R7 zero target", MID_A, HEAD_A, 32'hFFFFFFFE, 256'd0);
      check(found_o == 1'b0 && nonce_o == 32'h00000005, "R7 wrap last candidate",
            256'(nonce_o), 256'h5);
   endtask

   task automatic t_precheck();
      // R5: top target word zero, lower words all ones
      run_case("R5 top word zero", MID_A ^ {8{32'h5a5a5a5a}}, HEAD_A, 32'h00ABCDEF,
               {32'h0, {224{1'b1}}});
      // R5: top word of target just fits a known digest's top word
      run_case("R5 top word match", MID_A, HEAD_A, 32'h0000BEEF,
               ref_le(ref_double(MID_A, HEAD_A, 32'h0000BEEF)) | {32'h0, {224{1'b1}}});
   endtask

   task automatic t_hold();
      logic [31:0]  n0;
      logic [255:0] d0;
      run_case("R8 hit", MID_A, 96'hcafebabe_00000001_f0f0f0f0, 32'h7FFFFFFF, {256{1'b1}});
      n0 = nonce_o; d0 = digest_o;
      repeat (300) @(negedge clk);
      check(found_o && !busy_o, "R8 found held", 256'({found_o, busy_o}), 256'h2);
      check(nonce_o == n0 && digest_o == d0, "R8 result stable", digest_o, d0);
   endtask

   task automatic t_restart();
      pulse_start(MID_A, HEAD_A, 32'h00001000, 256'd0);
      repeat (100) @(negedge clk);
      check(busy_o == 1'b1, "R9 mid search busy", 256'(busy_o), 256'd1);
      run_case("R9 restart", ~MID_A, 96'h0a0b0c0d_0e0f1011_12131415, 32'h00C0FFEE, {256{1'b1}});
      check(nonce_o == 32'h00C0FFEE, "R9 new inputs used", 256'(nonce_o), 256'h00C0FFEE);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report_and_end();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_permissive();
      t_equal_boundary();
      t_zero_target_wrap();
      t_precheck();
      t_hold();
      t_restart();
      report_and_end();
   end

endmodule